// File: doc/BRIEF.md
# Single-Channel Bus-Hold DMA Engine

This block moves a block of words between one peripheral and memory without the processor handling each word. Software first writes a start address and a word count, then a control word that holds the go bit, the direction and the transfer mode. From then on the peripheral drives the work. It signals that it is ready on a request line. The engine then asks the processor for the bus with a hold request and waits for the grant. Only after the grant does it drive the memory master port.

Two bus policies are provided. In cycle-stealing mode the engine returns the bus after every word, so the processor keeps most of the bus time. In burst mode the engine keeps the bus until the last word of the block. When the remaining count reaches zero, the engine raises an interrupt. The interrupt stays high until software writes the clear bit. A start with a count of zero finishes at once, without a bus request.

Each word takes two bus cycles. In the first cycle the engine drives the memory strobe at the current address. In the second cycle it pulses the device acknowledge. In that second cycle the memory read data is passed straight through to the device, because memory read data arrives one cycle after the strobe. In the other direction, the device write data is passed straight through to memory during the strobe.

Top module: `dma_hold_ctrl`

## Requirements
- R1: While reset is active and right after it: hold, mem_en, mem_we, dev_ack and irq are low, and the status busy bit (status read bit 0) is 0.
- R2: Select 0 is the address register and select 1 is the count register. Both read back as their current values. A write to either one takes effect only while the engine is idle.
- R3: After a go command (select 2, bit 0), hold rises only when dev_req is high and holdack is low. The memory strobe mem_en is driven only while both hold and holdack are high.
- R4: Every word makes exactly one mem_en cycle, and dev_ack follows in the next cycle. Control bit 1 set means device to memory: mem_we is high and mem_wdata equals dev_rdata. Control bit 1 clear means memory to device: mem_we is low and dev_wdata equals mem_rdata during dev_ack.
- R5: After each word the address register goes up by one and the count register goes down by one.
- R6: In cycle-stealing mode (control bit 2 clear), hold falls in the cycle after each dev_ack. Hold rises again only after holdack has been seen low.
- R7: In burst mode (control bit 2 set), hold stays high from the first grant until the last dev_ack, even if dev_req drops between words.
- R8: When the count reaches zero, irq rises in the cycle after the last dev_ack, and busy returns to 0. Irq stays high until a write to select 3 with bit 0 set. Status read bit 1 reflects irq.
- R9: A go command given while the count is zero sets irq in the next cycle and never raises hold.
- R10: While busy, writes to the control, address and count registers have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 status |
| cfg_wdata | input | CPU_W | Register write data |
| cfg_rdata | output | CPU_W | Read data for the selected register |
| dev_req | input | 1 | Device ready for a word |
| dev_ack | output | 1 | One-cycle pulse when a word has been moved |
| dev_rdata | input | DW | Data from the device, written to memory |
| dev_wdata | output | DW | Data to the device, taken from memory |
| hold | output | 1 | Bus request to the processor |
| holdack | input | 1 | Bus grant from the processor |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read strobe |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions make two assumptions about the processor side. First, holdack never rises unless hold is already high. Second, once holdack is granted it stays high until hold falls. The assertions also assume that memory returns read data in the cycle after the strobe. The stimulus keeps to these rules. The bench processor raises holdack only after it has seen hold high for a chosen number of cycles, and drops holdack as soon as hold falls. The bench memory registers its read data. Dev_req is the only input that changes freely in the middle of a block.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_HOLD = 3'd2,
    ST_XFER = 3'd3,
    ST_ACK  = 3'd4
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_STAT  = 2'd3;

  localparam int CTRL_GO    = 0;
  localparam int CTRL_TOMEM = 1;
  localparam int CTRL_BURST = 2;

  localparam int STAT_BUSY  = 0;
  localparam int STAT_IRQ   = 1;
  localparam int STAT_CLR   = 0;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int CPU_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [CPU_W-1:0] cfg_wdata,
  input  logic             busy,
  input  logic             irq,
  input  logic [AW-1:0]    cur_addr,
  input  logic [CW-1:0]    cur_cnt,
  output logic             addr_ld,
  output logic             cnt_ld,
  output logic [AW-1:0]    ld_addr,
  output logic [CW-1:0]    ld_cnt,
  output logic             go,
  output logic             tomem_q,
  output logic             burst_q,
  output logic             irq_clr,
  output logic [CPU_W-1:0] cfg_rdata
);

  logic wr_addr, wr_cnt, wr_ctrl, wr_stat;
  logic tomem_d, burst_d, mode_en;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    wr_addr = cfg_wr && (cfg_sel == SEL_ADDR);
    wr_cnt  = cfg_wr && (cfg_sel == SEL_COUNT);
    wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
    wr_stat = cfg_wr && (cfg_sel == SEL_STAT);
  end

  assign addr_ld = wr_addr && !busy;
  assign cnt_ld  = wr_cnt && !busy;
  assign ld_addr = cfg_wdata[AW-1:0];
  assign ld_cnt  = cfg_wdata[CW-1:0];
  assign go      = wr_ctrl && cfg_wdata[CTRL_GO] && !busy;
  assign irq_clr = wr_stat && cfg_wdata[STAT_CLR];

  // mode bits are captured only with an accepted go command
  assign mode_en = go;
  always_comb begin
    tomem_d = tomem_q;
    burst_d = burst_q;
    if (mode_en) begin
      tomem_d = cfg_wdata[CTRL_TOMEM];
      burst_d = cfg_wdata[CTRL_BURST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tomem_q <= 1'b0;
      burst_q <= 1'b0;
    end else if (mode_en) begin
      tomem_q <= tomem_d;
      burst_q <= burst_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_ADDR:  cfg_rdata = CPU_W'(cur_addr);
      SEL_COUNT: cfg_rdata = CPU_W'(cur_cnt);
      SEL_CTRL:  begin
        cfg_rdata[CTRL_TOMEM] = tomem_q;
        cfg_rdata[CTRL_BURST] = burst_q;
      end
      default: begin
        cfg_rdata[STAT_BUSY] = busy;
        cfg_rdata[STAT_IRQ]  = irq;
      end
    endcase
  end

  // R10: mode bits never change while a block is running
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(tomem_q) && $stable(burst_q)));

endmodule

// File: rtl/dma_counters.sv
module dma_counters #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic          cnt_ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          cnt_zero,
  output logic          cnt_last
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          addr_en, cnt_en;

  always_comb begin
    addr_en = addr_ld || step;
    cnt_en  = cnt_ld || step;
    addr_d  = addr_ld ? ld_addr : cur_addr + 1'b1;
    cnt_d   = cnt_ld  ? ld_cnt  : cur_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
    end else if (addr_en) begin
      cur_addr <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cnt <= '0;
    end else if (cnt_en) begin
      cur_cnt <= cnt_d;
    end
  end

  assign cnt_zero = (cur_cnt == '0);
  assign cnt_last = (cur_cnt == CNT_ONE);

  // R5: a moved word advances the address and consumes one count
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_addr == $past(cur_addr) + 1'b1));
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_cnt == $past(cur_cnt) - 1'b1));
  // R5: a word is never moved with an exhausted count
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cnt_zero);

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic burst,
  input  logic dev_req,
  input  logic holdack,
  output logic hold,
  output logic mem_en,
  output logic word_done,
  output logic finish,
  output logic busy
);

  dma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) finish  = 1'b1;
          else          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dev_req && !holdack) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (holdack && dev_req) state_d = ST_XFER;
      end
      ST_XFER: begin
        state_d = ST_ACK;
      end
      ST_ACK: begin
        if (cnt_last) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else if (burst) begin
          state_d = ST_HOLD;
        end else begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign hold      = (state_q == ST_HOLD) || (state_q == ST_XFER) || (state_q == ST_ACK);
  assign mem_en    = (state_q == ST_XFER);
  assign word_done = (state_q == ST_ACK);
  assign busy      = (state_q != ST_IDLE);

  // R3: a new bus request only starts while the grant is low
  a_r3_hold_rise_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(!holdack));
  // R3: memory is touched only under an active grant
  a_r3_mem_granted: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (hold && holdack));
  // R4: every strobe is followed by the device acknowledge
  a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> word_done);
  // R6: cycle stealing gives the bus back after each word
  a_r6_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !burst) |=> !hold);
  // R7: burst keeps the bus until the final word
  a_r7_burst_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && burst && !cnt_last) |=> hold);

endmodule

// File: rtl/dma_hold_ctrl.sv
module dma_hold_ctrl
  import dma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 16,
  parameter int CPU_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [CPU_W-1:0] cfg_wdata,
  output logic [CPU_W-1:0] cfg_rdata,
  input  logic             dev_req,
  output logic             dev_ack,
  input  logic [DW-1:0]    dev_rdata,
  output logic [DW-1:0]    dev_wdata,
  output logic             hold,
  input  logic             holdack,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             irq
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  logic          addr_ld, cnt_ld, go, tomem_q, burst_q, irq_clr;
  logic [AW-1:0] ld_addr, cur_addr;
  logic [CW-1:0] ld_cnt, cur_cnt;
  logic          cnt_zero, cnt_last, word_done, finish, busy;
  logic          irq_q, irq_d;

  dma_regs #(.AW(AW), .CW(CW), .CPU_W(CPU_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .busy     (busy),
    .irq      (irq_q),
    .cur_addr (cur_addr),
    .cur_cnt  (cur_cnt),
    .addr_ld  (addr_ld),
    .cnt_ld   (cnt_ld),
    .ld_addr  (ld_addr),
    .ld_cnt   (ld_cnt),
    .go       (go),
    .tomem_q  (tomem_q),
    .burst_q  (burst_q),
    .irq_clr  (irq_clr),
    .cfg_rdata(cfg_rdata)
  );

  dma_counters #(.AW(AW), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_ni),
    .addr_ld (addr_ld),
    .cnt_ld  (cnt_ld),
    .ld_addr (ld_addr),
    .ld_cnt  (ld_cnt),
    .step    (word_done),
    .cur_addr(cur_addr),
    .cur_cnt (cur_cnt),
    .cnt_zero(cnt_zero),
    .cnt_last(cnt_last)
  );

  dma_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go       (go),
    .cnt_zero (cnt_zero),
    .cnt_last (cnt_last),
    .burst    (burst_q),
    .dev_req  (dev_req),
    .holdack  (holdack),
    .hold     (hold),
    .mem_en   (mem_en),
    .word_done(word_done),
    .finish   (finish),
    .busy     (busy)
  );

  // set has priority over a clear in the same cycle
  always_comb begin
    irq_d = finish || (irq_q && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq       = irq_q;
  assign dev_ack   = word_done;
  assign mem_we    = mem_en && tomem_q;
  assign mem_addr  = cur_addr;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;

  // R8: the interrupt is sticky until software clears it
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_q && !irq_clr) |=> irq_q);
  // R8: completion leaves the engine idle with the interrupt raised
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    (dev_ack && cnt_last) |=> (irq_q && !busy));
  // R9: a zero-length start completes without a bus request
  a_r9_zero_start: assert property (@(posedge clk) disable iff (!rst_ni)
    (go && cnt_zero) |=> (irq_q && !hold && !busy));

endmodule

// File: tb/sim_dma_hold_ctrl.sv
`timescale 1ns/1ps
module sim_dma_hold_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        dev_req;
  logic        dev_ack;
  logic [15:0] dev_rdata;
  logic [15:0] dev_wdata;
  logic        hold;
  logic        holdack;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int hold_lat = 0;
  int lat_cnt = 0;

  // behavioural model state
  int m_ph, m_addr, m_cnt;
  bit m_irq, m_dir, m_burst;

  logic [15:0] mem_img [64];

  always #2.5 clk = ~clk;

  dma_hold_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
    .hold(hold), .holdack(holdack), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  assign dev_rdata = 16'hC000 ^ 16'(m_addr);

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // bench memory: registered read data
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem_img[mem_addr[5:0]] <= mem_wdata;
      else        mem_rdata <= mem_img[mem_addr[5:0]];
    end
  end

  // bench processor: grants after hold_lat extra cycles, drops with hold
  always @(posedge clk) begin
    #1;
    if (!rst_n || !hold) begin
      holdack = 1'b0;
      lat_cnt = 0;
    end else if (!holdack) begin
      if (lat_cnt >= hold_lat) holdack = 1'b1;
      else lat_cnt++;
    end
  end

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_addr = 0; m_cnt = 0; m_irq = 0; m_dir = 0; m_burst = 0;
    end else begin
      if (cfg_wr && cfg_sel == 2'd3 && cfg_wdata[0]) m_irq = 0;
      case (m_ph)
        0: if (cfg_wr) begin
             if (cfg_sel == 2'd0) m_addr = int'(cfg_wdata[15:0]);
             if (cfg_sel == 2'd1) m_cnt = int'(cfg_wdata[15:0]);
             if (cfg_sel == 2'd2 && cfg_wdata[0]) begin
               m_dir = cfg_wdata[1];
               m_burst = cfg_wdata[2];
               if (m_cnt == 0) m_irq = 1;
               else m_ph = 1;
             end
           end
        1: if (dev_req && !holdack) m_ph = 2;
        2: if (holdack && dev_req) m_ph = 3;
        3: m_ph = 4;
        default: begin
          m_addr = (m_addr + 1) & 16'hFFFF;
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) begin m_irq = 1; m_ph = 0; end
          else m_ph = m_burst ? 2 : 1;
        end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    chk("R3 R6 R7 hold", 32'(hold), 32'(m_ph >= 2));
    chk("R3 R4 mem_en", 32'(mem_en), 32'(m_ph == 3));
    chk("R4 mem_we", 32'(mem_we), 32'(m_ph == 3 && m_dir));
    chk("R4 dev_ack", 32'(dev_ack), 32'(m_ph == 4));
    chk("R8 irq", 32'(irq), 32'(m_irq));
    if (cfg_sel == 2'd3) chk("R8 busy/irq status", cfg_rdata[1:0], {30'd0, m_irq, m_ph != 0});
    if (m_ph == 3) chk("R5 mem_addr", 32'(mem_addr), 32'(m_addr));
    if (m_ph == 3 && m_dir) chk("R4 mem_wdata", 32'(mem_wdata), 32'(16'hC000 ^ 16'(m_addr)));
    if (m_ph == 4 && !m_dir) chk("R4 dev_wdata", 32'(dev_wdata), 32'(mem_img[m_addr[5:0]]));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); #0.5;
    cfg_sel = s;
    #0.5 v = cfg_rdata;
    cfg_sel = 2'd3;
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  logic [31:0] v;
  int gaps, seen, rises;
  logic prev_hold;

  initial begin
    for (int i = 0; i < 64; i++) mem_img[i] = 16'h5A00 + 16'(i * 7);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd3; cfg_wdata = '0;
    dev_req = 1'b0; holdack = 1'b0; mem_rdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {27'd0, hold, mem_en, mem_we, dev_ack, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 idle after reset", {28'd0, hold, mem_en, irq, cfg_rdata[0]}, 32'd0);

    // memory to device, cycle stealing
    wr(2'd0, 32'h10); wr(2'd1, 32'd4);
    rd(2'd0, v); chk("R2 address readback", v, 32'h10);
    rd(2'd1, v); chk("R2 count readback", v, 32'd4);
    dev_req = 1'b1;
    wr(2'd2, 32'h1);
    wait_irq();
    chk("R8 irq at end", 32'(irq), 32'd1);
    rd(2'd0, v); chk("R5 final address", v, 32'h14);
    rd(2'd1, v); chk("R5 final count", v, 32'd0);

    repeat (5) @(posedge clk);
    @(negedge clk); chk("R8 irq still set", 32'(irq), 32'd1);
    wr(2'd3, 32'h1);
    @(negedge clk); chk("R8 irq cleared", 32'(irq), 32'd0);

    // device to memory, burst
    wr(2'd0, 32'h20); wr(2'd1, 32'd3);
    wr(2'd2, 32'h7);
    wait_irq();
    for (int i = 0; i < 3; i++)
      chk("R4 memory written", 32'(mem_img[6'h20 + 6'(i)]), 32'(16'hC000 ^ 16'(32 + i)));
    wr(2'd3, 32'h1);

    // zero-length start
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk("R9 zero start irq", 32'(irq), 32'd1);
    chk("R9 zero start no hold", 32'(hold), 32'd0);
    wr(2'd3, 32'h1);

    // writes while busy are ignored
    dev_req = 1'b0;
    wr(2'd0, 32'h30); wr(2'd1, 32'd2); wr(2'd2, 32'h1);
    wr(2'd0, 32'h99); wr(2'd1, 32'd7); wr(2'd2, 32'h5);
    rd(2'd0, v); chk("R10 address kept while busy", v, 32'h30);
    rd(2'd1, v); chk("R10 count kept while busy", v, 32'd2);
    dev_req = 1'b1;
    wait_irq();
    rd(2'd0, v); chk("R10 block length unchanged", v, 32'h32);
    wr(2'd3, 32'h1);

    // burst with gaps in device readiness
    wr(2'd0, 32'h08); wr(2'd1, 32'd4); wr(2'd2, 32'h5);
    gaps = 0; seen = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (hold) seen = 1;
      if (irq) break;
      if (seen != 0 && !hold) gaps++;
      @(posedge clk); #1;
      dev_req = (k % 3) != 2;
    end
    chk("R7 bus kept through burst", 32'(gaps), 32'd0);
    dev_req = 1'b1;
    wr(2'd3, 32'h1);

    // cycle stealing with slow grant: one hold per word
    hold_lat = 3;
    wr(2'd0, 32'h40); wr(2'd1, 32'd3); wr(2'd2, 32'h3);
    rises = 0; prev_hold = 1'b0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (hold && !prev_hold) rises++;
      prev_hold = hold;
      if (irq) break;
    end
    chk("R6 one bus request per word", 32'(rises), 32'd3);
    wr(2'd3, 32'h1);
    repeat (3) @(posedge clk);

    summary();
    $finish;
  end

endmodule